// File: doc/BRIEF.md
# Prioritized Multi-Channel RAM Access Port

This block lets several independent requesters share the single port of a synchronous block RAM. Typical requesters are a slow host-processor bridge and a few fast fill, draw and copy engines. Each channel drives an address, write data, an auxiliary tag, a read request and a write request. A fixed-priority selector picks one channel per clock, and that channel is serviced in the same clock with no wait states. Channel 0 is the most urgent. A channel that loses simply keeps its request asserted until its grant bit comes up.

Writes complete in the granted clock. A granted read returns through a fixed-length pipeline whose depth equals the RAM read latency. When the read emerges, the shared read-data bus carries the word, the address that was requested and the tag that came with it. A one-hot ready vector marks the channel that owns the result. There is no handshake: ready is only the accepted read request, delayed.

Top module: `mc_ram_port`

## Requirements
- R1: While reset is high, and in every cycle after a reset edge until a new read is granted, `rd_ready` is all zeros, even if a read was granted just before reset.
- R2: `ch_grant` is one-hot or zero. It is nonzero exactly when some channel asserts `ch_rd_req` or `ch_wr_req`, and it selects the lowest-numbered such channel (bit i of every per-channel vector belongs to channel i).
- R3: A granted read raises only that channel's bit of `rd_ready`, exactly RD_LATENCY clocks after the clock in which it was granted (default 2), and it raises it for one clock.
- R4: `rd_data` presented with a ready pulse equals the last word written to the read address before the read was granted.
- R5: `rd_addr` and `rd_tag` presented with a ready pulse equal the address and tag that the granted channel drove in its grant cycle.
- R6: A granted write stores `ch_wdata` at `ch_addr` of that channel in the grant clock, produces no ready pulse, and is visible to a read granted in the following clock.
- R7: A channel that asserts read and write together is treated as a write: the word is stored and no ready pulse is produced.
- R8: A channel that loses arbitration gets no grant and no ready pulse for that cycle. If it holds its request, it is served once higher-priority channels go quiet.
- R9: Reads granted in consecutive clocks, from any mix of channels, produce ready pulses in consecutive clocks with no gap.
- R10: A write request that loses arbitration leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_addr | input | CHANNELS*ADDR_W | Per-channel word address, channel i at bits [i*ADDR_W +: ADDR_W] |
| ch_wdata | input | CHANNELS*DATA_W | Per-channel write data |
| ch_tag | input | CHANNELS*TAG_W | Per-channel auxiliary tag carried with reads |
| ch_rd_req | input | CHANNELS | Per-channel read request |
| ch_wr_req | input | CHANNELS | Per-channel write request |
| ch_grant | output | CHANNELS | One-hot acceptance of this cycle's request |
| rd_ready | output | CHANNELS | One-hot strobe naming the owner of the returned word |
| rd_data | output | DATA_W | Returned read word, shared by all channels |
| rd_addr | output | ADDR_W | Address of the returned word |
| rd_tag | output | TAG_W | Tag of the returned word |

## Verification
Arbitration and the return of an earlier read fall in the same clock whenever reads are issued back to back. A new grant is being decided while the result of the read granted RD_LATENCY clocks earlier leaves the pipeline. The bench provokes this by walking a vector table with no idle clocks between entries, mixing contested reads, contested writes and a channel that raises both requests. At the start of each entry it compares the ready, data, address and tag against a scoreboard entry recorded RD_LATENCY entries before. Within the same entry it then checks the new grant against the lowest requesting channel. A reset applied while a read is in flight checks that the in-flight result is dropped.

// File: rtl/mcrp_pkg.sv
package mcrp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mcrp_prio_sel.sv
module mcrp_prio_sel #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] win,
  output logic             any
);

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        win = IDX_W'(i);
        any = 1'b1;
      end
    end
    grant = any ? (N'(1) << win) : '0;
  end

endmodule

// File: rtl/mcrp_bram.sv
module mcrp_bram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q   [LAT];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    q[0] <= mem[raddr];
    for (int s = 1; s < LAT; s++) begin
      q[s] <= q[s-1];
    end
  end

  assign rdata = q[LAT-1];

endmodule

// File: rtl/mcrp_tag_pipe.sv
module mcrp_tag_pipe #(
  parameter int unsigned N      = 5,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TAG_W-1:0]  in_tag,
  output logic [N-1:0]      out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [TAG_W-1:0]  out_tag
);

  logic [N-1:0]      v [LAT];
  logic [ADDR_W-1:0] a [LAT];
  logic [TAG_W-1:0]  t [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < LAT; s++) begin
        v[s] <= '0;
      end
    end else begin
      v[0] <= in_valid;
      for (int s = 1; s < LAT; s++) begin
        v[s] <= v[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    a[0] <= in_addr;
    t[0] <= in_tag;
    for (int s = 1; s < LAT; s++) begin
      a[s] <= a[s-1];
      t[s] <= t[s-1];
    end
  end

  assign out_valid = v[LAT-1];
  assign out_addr  = a[LAT-1];
  assign out_tag   = t[LAT-1];

endmodule

// File: rtl/mc_ram_port.sv
module mc_ram_port
  import mcrp_pkg::*;
#(
  parameter int unsigned CHANNELS   = 5,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TAG_W      = 3,
  parameter int unsigned RD_LATENCY = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CHANNELS*ADDR_W-1:0]   ch_addr,
  input  logic [CHANNELS*DATA_W-1:0]   ch_wdata,
  input  logic [CHANNELS*TAG_W-1:0]    ch_tag,
  input  logic [CHANNELS-1:0]          ch_rd_req,
  input  logic [CHANNELS-1:0]          ch_wr_req,
  output logic [CHANNELS-1:0]          ch_grant,
  output logic [CHANNELS-1:0]          rd_ready,
  output logic [DATA_W-1:0]            rd_data,
  output logic [ADDR_W-1:0]            rd_addr,
  output logic [TAG_W-1:0]             rd_tag
);

  localparam int unsigned IDX_W = idx_width(CHANNELS);

  logic [ADDR_W-1:0] addr_a [CHANNELS];
  logic [DATA_W-1:0] data_a [CHANNELS];
  logic [TAG_W-1:0]  tag_a  [CHANNELS];

  genvar gi;
  generate
    for (gi = 0; gi < CHANNELS; gi++) begin : g_unpack
      assign addr_a[gi] = ch_addr [gi*ADDR_W +: ADDR_W];
      assign data_a[gi] = ch_wdata[gi*DATA_W +: DATA_W];
      assign tag_a[gi]  = ch_tag  [gi*TAG_W  +: TAG_W];
    end
  endgenerate

  logic [CHANNELS-1:0] req_any;
  logic [IDX_W-1:0]    win;
  logic                any;
  port_op_e            op;
  logic [ADDR_W-1:0]   sel_addr;
  logic [DATA_W-1:0]   sel_data;
  logic [TAG_W-1:0]    sel_tag;
  logic [CHANNELS-1:0] rd_launch;

  assign req_any = ch_rd_req | ch_wr_req;

  mcrp_prio_sel #(.N(CHANNELS), .IDX_W(IDX_W)) u_sel (
    .req   (req_any),
    .grant (ch_grant),
    .win   (win),
    .any   (any)
  );

  always_comb begin
    sel_addr = addr_a[win];
    sel_data = data_a[win];
    sel_tag  = tag_a[win];
    if (!any)
      op = OP_IDLE;
    else if (ch_wr_req[win])
      op = OP_WRITE;
    else
      op = OP_READ;
    rd_launch = (op == OP_READ) ? ch_grant : '0;
  end

  mcrp_bram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(RD_LATENCY)) u_ram (
    .clk   (clk),
    .we    (op == OP_WRITE),
    .waddr (sel_addr),
    .wdata (sel_data),
    .raddr (sel_addr),
    .rdata (rd_data)
  );

  mcrp_tag_pipe #(
    .N(CHANNELS), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .LAT(RD_LATENCY)
  ) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_launch),
    .in_addr   (sel_addr),
    .in_tag    (sel_tag),
    .out_valid (rd_ready),
    .out_addr  (rd_addr),
    .out_tag   (rd_tag)
  );

endmodule

// File: rtl/mcrp_port_chk.sv
module mcrp_port_chk #(
  parameter int unsigned CHANNELS   = 5,
  parameter int unsigned RD_LATENCY = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [CHANNELS-1:0] ch_rd_req,
  input logic [CHANNELS-1:0] ch_wr_req,
  input logic [CHANNELS-1:0] ch_grant,
  input logic [CHANNELS-1:0] rd_ready
);

  logic [CHANNELS-1:0] req;
  logic [CHANNELS-1:0] sh [RD_LATENCY];

  assign req = ch_rd_req | ch_wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < RD_LATENCY; s++) sh[s] <= '0;
    end else begin
      sh[0] <= ch_grant & ch_rd_req & ~ch_wr_req;
      for (int s = 1; s < RD_LATENCY; s++) sh[s] <= sh[s-1];
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (rd_ready == '0));

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_grant));

  assert_grant_when_req_R2: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (ch_grant != '0));

  assert_grant_lowest_R2: assert property (@(posedge clk) disable iff (rst)
    (ch_grant != '0) |-> (((ch_grant - 1'b1) & req) == '0));

  assert_grant_only_req_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_grant & ~req) == '0);

  assert_ready_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_ready));

  // R7: a read+write channel is excluded from sh, so no ready may follow
  assert_ready_timing_R3: assert property (@(posedge clk) disable iff (rst)
    rd_ready == sh[RD_LATENCY-1]);

endmodule

bind mc_ram_port mcrp_port_chk #(
  .CHANNELS(CHANNELS), .RD_LATENCY(RD_LATENCY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ch_rd_req (ch_rd_req),
  .ch_wr_req (ch_wr_req),
  .ch_grant  (ch_grant),
  .rd_ready  (rd_ready)
);

// File: tb/mc_ram_port_test.sv
`timescale 1ns/1ps
module mc_ram_port_test;

  localparam int CH  = 5;
  localparam int AW  = 10;
  localparam int DW  = 16;
  localparam int TW  = 3;
  localparam int LAT = 2;
  localparam int NV  = 16;

  // {rd[4:0], wr[4:0], base addr, base data}; channel i uses base+i
  localparam logic [35:0] VEC [NV] = '{
    {5'b00000, 5'b00001, 10'd10, 16'hA000}, // R6 ch0 writes 10
    {5'b00000, 5'b01000, 10'd20, 16'hB000}, // R6 ch3 writes 23
    {5'b00001, 5'b00000, 10'd10, 16'h0000}, // R4 read 10
    {5'b01000, 5'b00000, 10'd20, 16'h0000}, // R4 read 23
    {5'b10010, 5'b00000, 10'd9,  16'h0000}, // R8 ch1 beats ch4
    {5'b10000, 5'b00000, 10'd19, 16'h0000}, // R8 ch4 held, served
    {5'b00000, 5'b00100, 10'd30, 16'hD000}, // R6 ch2 writes 32
    {5'b00000, 5'b00101, 10'd30, 16'hC000}, // R10 ch2 write lost
    {5'b00100, 5'b00000, 10'd30, 16'h0000}, // R10 32 unchanged
    {5'b00010, 5'b00010, 10'd40, 16'hE000}, // R7 rd+wr -> write
    {5'b00010, 5'b00000, 10'd40, 16'h0000}, // R6 read next clock
    {5'b10000, 5'b00000, 10'd26, 16'h0003}, // R9 back to back
    {5'b01000, 5'b00000, 10'd7,  16'h0005}, // R9
    {5'b00100, 5'b00000, 10'd30, 16'h0006}, // R9
    {5'b00001, 5'b00000, 10'd41, 16'h0001}, // R9
    {5'b00010, 5'b10000, 10'd22, 16'hF000}  // R8 read beats write
  };
  localparam string VTAG [NV] = '{"R6","R6","R4","R4","R8","R8","R6","R10",
                                  "R10","R7","R6","R9","R9","R9","R9","R8"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CH*AW-1:0] ch_addr  = '0;
  logic [CH*DW-1:0] ch_wdata = '0;
  logic [CH*TW-1:0] ch_tag   = '0;
  logic [CH-1:0]    ch_rd_req = '0;
  logic [CH-1:0]    ch_wr_req = '0;
  logic [CH-1:0]    ch_grant;
  logic [CH-1:0]    rd_ready;
  logic [DW-1:0]    rd_data;
  logic [AW-1:0]    rd_addr;
  logic [TW-1:0]    rd_tag;

  always #5 clk = ~clk;

  mc_ram_port #(.CHANNELS(CH), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW),
                .RD_LATENCY(LAT)) uut (
    .clk(clk), .rst(rst), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
    .ch_tag(ch_tag), .ch_rd_req(ch_rd_req), .ch_wr_req(ch_wr_req),
    .ch_grant(ch_grant), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_addr(rd_addr), .rd_tag(rd_tag));

  int tests = 0;
  int fails = 0;
  int stepn = 0;
  logic [DW-1:0] mdl   [1024];
  logic [CH-1:0] h_rdy [256];
  logic [DW-1:0] h_dat [256];
  logic [AW-1:0] h_adr [256];
  logic [TW-1:0] h_tag [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [35:0] v, input string vt);
    logic [CH-1:0] rd, wr, req, eg, er;
    logic [AW-1:0] base;
    logic [DW-1:0] dat;
    int w;
    @(negedge clk);
    er = (stepn >= LAT) ? h_rdy[stepn-LAT] : '0;
    chk(rd_ready == er, {"R3 ", vt}, "rd_ready", 32'(rd_ready), 32'(er));
    if (er != '0) begin
      chk(rd_data == h_dat[stepn-LAT], {"R4 ", vt}, "rd_data",
          32'(rd_data), 32'(h_dat[stepn-LAT]));
      chk(rd_addr == h_adr[stepn-LAT], {"R5 ", vt}, "rd_addr",
          32'(rd_addr), 32'(h_adr[stepn-LAT]));
      chk(rd_tag == h_tag[stepn-LAT], {"R5 ", vt}, "rd_tag",
          32'(rd_tag), 32'(h_tag[stepn-LAT]));
    end
    rd = v[35:31]; wr = v[30:26]; base = v[25:16]; dat = v[15:0];
    for (int i = 0; i < CH; i++) begin
      ch_addr [i*AW +: AW] = AW'(base + AW'(i));
      ch_wdata[i*DW +: DW] = DW'(dat + DW'(i));
      ch_tag  [i*TW +: TW] = dat[TW-1:0] ^ TW'(i);
    end
    ch_rd_req = rd;
    ch_wr_req = wr;
    #1;
    req = rd | wr;
    w = -1;
    for (int i = CH - 1; i >= 0; i--) if (req[i]) w = i;
    eg = (w < 0) ? '0 : CH'(1) << w;
    chk(ch_grant == eg, {"R2 ", vt}, "ch_grant", 32'(ch_grant), 32'(eg));
    h_rdy[stepn] = '0;
    if (w >= 0) begin
      h_adr[stepn] = AW'(base + AW'(w));
      h_tag[stepn] = dat[TW-1:0] ^ TW'(w);
      h_dat[stepn] = mdl[h_adr[stepn]];
      if (wr[w]) mdl[h_adr[stepn]] = DW'(dat + DW'(w));
      else h_rdy[stepn] = eg;
    end
    stepn++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_ready == '0, "R1", "rd_ready in reset", 32'(rd_ready), 0);
    chk(ch_grant == '0, "R2", "idle grant", 32'(ch_grant), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) step(VEC[k], VTAG[k]);
    for (int k = 0; k < LAT + 1; k++) step(36'd0, "R9 flush");

    // R1: reset while a read is in flight drops the result
    step({5'b00001, 5'b00000, 10'd10, 16'h0000}, "R1 arm");
    @(negedge clk);
    rst = 1'b1;
    ch_rd_req = '0;
    ch_wr_req = '0;
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      rst = 1'b0;
      chk(rd_ready == '0, "R1", "ready after reset", 32'(rd_ready), 0);
    end
    stepn = 0;

    // R6 after reset: memory kept, write then read at once
    step({5'b00000, 5'b00100, 10'd60, 16'h5A00}, "R6");
    step({5'b00100, 5'b00000, 10'd60, 16'h0000}, "R6");
    step({5'b00001, 5'b00000, 10'd10, 16'h0000}, "R4");
    for (int k = 0; k < LAT + 1; k++) step(36'd0, "R3 flush");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule